// File: doc/BRIEF.md
# Four-Lane Smoothed Edge Gradient Pipeline

This block turns a raster grayscale video stream into a per-pixel edge strength and edge orientation map. Each input beat carries four horizontally adjacent 8-bit pixels. The block first smooths the image with a 3x3 binomial filter. It then takes horizontal and vertical 3x3 derivative responses of the smoothed image. From these it forms an L1 gradient magnitude, clipped to 8 bits, and a direction quantised into four bins. Each output beat carries the four results for the four pixels of one input beat.

Both 3x3 stages use a trailing window. The result delivered at position (row y, column x) is built from rows y-2..y and columns x-2..x of the stage's input. Indices below zero are replaced by index zero, so the top rows and left columns repeat the nearest real pixel. Because no look-ahead is needed, every accepted beat produces exactly one output beat after a fixed number of pipeline steps, and no flush is required at the end of a line or frame. Line length is set at run time by the end-of-line flag, up to the MAX_W parameter. Each stage keeps two lines of history in memories that are one beat wide, so each stored line costs one read and one write per beat.

Both stream sides use valid/ready. A beat moves when valid and ready are both high at a rising clock edge. The producer must hold an offered input beat unchanged until it is taken. in_ready is high exactly when the output register is empty or the consumer is ready. While out_valid is high and out_ready is low, the whole pipeline freezes and the output beat stays unchanged.

Top module: `edge_grad_pipe`

## Requirements
- R1: Every accepted input beat yields exactly one output beat, in acceptance order. Lane k of in_data is bits [8k+7:8k]. Lane k of out_data is bits [10k+9:10k], laid out as {direction[1:0], magnitude[7:0]}. No beat is produced that was not accepted.
- R2: The smoothed value S(y,x) is the weighted sum of input pixels over rows y-2..y and columns x-2..x, shifted right by 4. The weights are 1 2 1 / 2 4 2 / 1 2 1, with 4 on the centre tap at (y-1, x-1).
- R3: The gradients are taken over S at rows y-2..y and columns x-2..x. GX is (column x minus column x-2), with row weights 1,2,1. GY is (row y minus row y-2), with column weights 1,2,1.
- R4: The magnitude is |GX|+|GY|, clipped to 255.
- R5: The direction code is 0 when 256*|GY| <= 106*|GX|. Otherwise it is 2 when 256*|GY| >= 618*|GX|. Otherwise it is 1 when GX and GY have the same sign, and 3 when they do not. A zero magnitude always gives code 0.
- R6: In both stages, a row index below zero reads row 0 and a column index below zero reads column 0. At the first beat of a line, the missing left neighbours are copies of lane 0.
- R7: Lanes 0 and 1 take their left neighbours from lanes 2 and 3 of the previous beat of the same line.
- R8: out_sof and out_eol equal the in_sof and in_eol of the input beat that produced the output beat.
- R9: in_ready is (!out_valid || out_ready). While out_valid is high and out_ready is low, out_valid, out_data and the flags stay unchanged on the next cycle.
- R10: With the pipeline empty and out_ready high, a beat accepted at rising edge n is shown on the outputs from edge n+4.
- R11: After reset, out_valid is low and in_ready is high. A beat with in_sof restarts the row and column counting, so a new frame uses no data from an earlier frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block can take the input beat |
| in_data | input | 32 | Four 8-bit pixels, lane 0 lowest |
| in_sof | input | 1 | Beat is the first of a frame |
| in_eol | input | 1 | Beat is the last of a line |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | 40 | Four {direction, magnitude} results, lane 0 lowest |
| out_sof | output | 1 | Start-of-frame flag of the source beat |
| out_eol | output | 1 | End-of-line flag of the source beat |

## Verification
There are five pipeline registers between acceptance and the output: the smoothing window, the smoothed value, the gradient window, the gradients, and the output. A beat taken at edge n therefore appears from edge n+4, and any stall pushes it later by the number of stalled cycles. The bench changes its inputs at the falling edge and samples 1 ns after it. It records a handshake only where valid and ready are both high in that sample, and it matches outputs to inputs by handshake order, never by cycle count. A dedicated single-beat test on an empty pipeline counts the samples after acceptance and expects out_valid to stay low for four of them and go high on the fifth.

// File: rtl/edge_pipe_pkg.sv
package edge_pipe_pkg;

  // Quantised gradient orientation.
  typedef enum logic [1:0] {
    DIR_0   = 2'd0,
    DIR_45  = 2'd1,
    DIR_90  = 2'd2,
    DIR_135 = 2'd3
  } dir_e;

  // Fixed-point tangent bounds, scaled by 2**TAN_FRAC.
  localparam int TAN_FRAC = 8;
  localparam int TAN_LO   = 106;  // about tan(22.5 deg) * 256
  localparam int TAN_HI   = 618;  // about tan(67.5 deg) * 256

  // Pipeline registers between acceptance and the output port.
  localparam int PIPE_STAGES = 5;

endpackage

// File: rtl/ep_window.sv
// 3x3 trailing neighbourhood former, shared across all lanes of a beat.
// Keeps two lines of history, one beat-wide word per column position.
// Requires LANES >= 2.
module ep_window #(
  parameter int LANES = 4,
  parameter int PW    = 8,
  parameter int MAX_W = 256
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  en,
  input  logic                                  in_v,
  input  logic [LANES-1:0][PW-1:0]              in_pix,
  input  logic                                  in_sof,
  input  logic                                  in_eol,
  output logic                                  w_v,
  output logic                                  w_sof,
  output logic                                  w_eol,
  output logic [LANES-1:0][2:0][2:0][PW-1:0]    w_win
);

  localparam int DEPTH = MAX_W / LANES;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef logic [LANES-1:0][PW-1:0] beat_t;
  typedef logic [2:0][PW-1:0]       colv_t;  // [0]=row y-2, [2]=row y

  beat_t mem_up1 [DEPTH];  // row y-1
  beat_t mem_up2 [DEPTH];  // row y-2

  logic [AW-1:0] col_q, col_c;
  logic [1:0]    row_q, row_c;   // saturates at 2
  beat_t         rd1, rd2, row_top, row_mid;
  colv_t         ext [LANES+2];  // ext[k+2] is lane k, ext[0..1] left neighbours
  colv_t         prev_q [2];
  logic          acc;

  assign acc = en && in_v;

  always_comb begin
    col_c = in_sof ? '0 : col_q;
    row_c = in_sof ? 2'd0 : row_q;
    rd1   = mem_up1[col_c];
    rd2   = mem_up2[col_c];
    // Vertical replication at the top of the frame.
    case (row_c)
      2'd0:    begin row_top = in_pix; row_mid = in_pix; end
      2'd1:    begin row_top = rd1;    row_mid = rd1;    end
      default: begin row_top = rd2;    row_mid = rd1;    end
    endcase
    for (int k = 0; k < LANES; k++) begin
      ext[k+2][0] = row_top[k];
      ext[k+2][1] = row_mid[k];
      ext[k+2][2] = in_pix[k];
    end
    // Horizontal replication at the start of a line, else previous beat.
    for (int k = 0; k < 2; k++) begin
      ext[k] = (col_c == '0) ? ext[2] : prev_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_v       <= 1'b0;
      w_sof     <= 1'b0;
      w_eol     <= 1'b0;
      w_win     <= '0;
      prev_q[0] <= '0;
      prev_q[1] <= '0;
      col_q     <= '0;
      row_q     <= 2'd0;
    end else if (en) begin
      w_v <= in_v;
      if (in_v) begin
        w_sof <= in_sof;
        w_eol <= in_eol;
        for (int l = 0; l < LANES; l++) begin
          for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 3; c++) begin
              w_win[l][r][c] <= ext[l+c][r];
            end
          end
        end
        prev_q[0] <= ext[LANES];
        prev_q[1] <= ext[LANES+1];
        col_q     <= in_eol ? '0 : col_c + AW'(1);
        row_q     <= in_eol ? ((row_c == 2'd2) ? 2'd2 : row_c + 2'd1) : row_c;
      end
    end
  end

  // One read and one write per memory per accepted beat.
  always_ff @(posedge clk) begin
    if (acc) begin
      mem_up1[col_c] <= in_pix;
      mem_up2[col_c] <= rd1;
    end
  end

  // R6: a frame's first beat yields a lane 0 window made only of its lane 0 pixel.
  p_sof_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_sof) |=> (w_win[0][0][0] == $past(in_pix[0])) &&
                        (w_win[0][1][1] == $past(in_pix[0])) &&
                        (w_win[0][2][2] == $past(in_pix[0])) &&
                        (w_win[0][0][2] == $past(in_pix[0])));

endmodule

// File: rtl/ep_smooth.sv
// Binomial 3x3 smoothing, one result per lane, registered.
module ep_smooth #(
  parameter int LANES = 4,
  parameter int PW    = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 en,
  input  logic                                 w_v,
  input  logic                                 w_sof,
  input  logic                                 w_eol,
  input  logic [LANES-1:0][2:0][2:0][PW-1:0]   w_win,
  output logic                                 g_v,
  output logic                                 g_sof,
  output logic                                 g_eol,
  output logic [LANES-1:0][PW-1:0]             g_pix
);

  localparam int SW = PW + 4;

  logic [SW-1:0] sum_c [LANES];
  logic          flat_c [LANES];

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      sum_c[l]  = '0;
      flat_c[l] = 1'b1;
      for (int r = 0; r < 3; r++) begin
        for (int c = 0; c < 3; c++) begin
          sum_c[l] = sum_c[l] +
            (SW'(w_win[l][r][c]) << (((r == 1) ? 1 : 0) + ((c == 1) ? 1 : 0)));
          if (w_win[l][r][c] != w_win[l][1][1]) flat_c[l] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_v   <= 1'b0;
      g_sof <= 1'b0;
      g_eol <= 1'b0;
      g_pix <= '0;
    end else if (en) begin
      g_v <= w_v;
      if (w_v) begin
        g_sof <= w_sof;
        g_eol <= w_eol;
        for (int l = 0; l < LANES; l++) g_pix[l] <= PW'(sum_c[l] >> 4);
      end
    end
  end

  generate
    for (genvar gl = 0; gl < LANES; gl++) begin : g_chk
      // R2: a uniform window smooths to its own value.
      p_flat_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && w_v && flat_c[gl]) |=> (g_pix[gl] == $past(w_win[gl][1][1])));
    end
  endgenerate

endmodule

// File: rtl/ep_grad.sv
// Horizontal and vertical 3x3 derivative responses, registered.
module ep_grad #(
  parameter int LANES = 4,
  parameter int PW    = 8,
  parameter int GW    = PW + 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 en,
  input  logic                                 w_v,
  input  logic                                 w_sof,
  input  logic                                 w_eol,
  input  logic [LANES-1:0][2:0][2:0][PW-1:0]   w_win,
  output logic                                 d_v,
  output logic                                 d_sof,
  output logic                                 d_eol,
  output logic signed [GW-1:0]                 d_gx [LANES],
  output logic signed [GW-1:0]                 d_gy [LANES]
);

  logic signed [GW-1:0] gx_c [LANES];
  logic signed [GW-1:0] gy_c [LANES];
  logic                 flat_c [LANES];

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      int sx;
      int sy;
      sx = 0;
      sy = 0;
      flat_c[l] = 1'b1;
      for (int i = 0; i < 3; i++) begin
        int wt;
        wt = (i == 1) ? 2 : 1;
        sx = sx + wt * (int'(w_win[l][i][2]) - int'(w_win[l][i][0]));
        sy = sy + wt * (int'(w_win[l][2][i]) - int'(w_win[l][0][i]));
        for (int j = 0; j < 3; j++) begin
          if (w_win[l][i][j] != w_win[l][0][0]) flat_c[l] = 1'b0;
        end
      end
      gx_c[l] = GW'(sx);
      gy_c[l] = GW'(sy);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_v   <= 1'b0;
      d_sof <= 1'b0;
      d_eol <= 1'b0;
      for (int l = 0; l < LANES; l++) begin
        d_gx[l] <= '0;
        d_gy[l] <= '0;
      end
    end else if (en) begin
      d_v <= w_v;
      if (w_v) begin
        d_sof <= w_sof;
        d_eol <= w_eol;
        for (int l = 0; l < LANES; l++) begin
          d_gx[l] <= gx_c[l];
          d_gy[l] <= gy_c[l];
        end
      end
    end
  end

  generate
    for (genvar gl = 0; gl < LANES; gl++) begin : g_chk
      // R3: a uniform smoothed window has no gradient.
      p_flat_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && w_v && flat_c[gl]) |=> (d_gx[gl] == '0) && (d_gy[gl] == '0));
    end
  endgenerate

endmodule

// File: rtl/ep_magdir.sv
// L1 magnitude with clipping and four-bin direction, registered.
module ep_magdir
  import edge_pipe_pkg::*;
#(
  parameter int LANES = 4,
  parameter int PW    = 8,
  parameter int GW    = PW + 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic                          d_v,
  input  logic                          d_sof,
  input  logic                          d_eol,
  input  logic signed [GW-1:0]          d_gx [LANES],
  input  logic signed [GW-1:0]          d_gy [LANES],
  output logic                          o_v,
  output logic                          o_sof,
  output logic                          o_eol,
  output logic [LANES-1:0][PW-1:0]      o_mag,
  output dir_e                          o_dir [LANES]
);

  localparam int LIM = (1 << PW) - 1;

  logic [PW-1:0] mag_c [LANES];
  dir_e          dir_c [LANES];

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      int gx;
      int gy;
      int ax;
      int ay;
      int s;
      gx = int'(d_gx[l]);
      gy = int'(d_gy[l]);
      ax = (gx < 0) ? -gx : gx;
      ay = (gy < 0) ? -gy : gy;
      s  = ax + ay;
      mag_c[l] = PW'((s > LIM) ? LIM : s);
      if ((ay << TAN_FRAC) <= TAN_LO * ax)      dir_c[l] = DIR_0;
      else if ((ay << TAN_FRAC) >= TAN_HI * ax) dir_c[l] = DIR_90;
      else if ((gx < 0) == (gy < 0))            dir_c[l] = DIR_45;
      else                                      dir_c[l] = DIR_135;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_v   <= 1'b0;
      o_sof <= 1'b0;
      o_eol <= 1'b0;
      o_mag <= '0;
      for (int l = 0; l < LANES; l++) o_dir[l] <= DIR_0;
    end else if (en) begin
      o_v <= d_v;
      if (d_v) begin
        o_sof <= d_sof;
        o_eol <= d_eol;
        for (int l = 0; l < LANES; l++) begin
          o_mag[l] <= mag_c[l];
          o_dir[l] <= dir_c[l];
        end
      end
    end
  end

  generate
    for (genvar gl = 0; gl < LANES; gl++) begin : g_chk
      // R5: zero gradient strength always reports the horizontal bin.
      p_zero_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (o_v && (o_mag[gl] == '0)) |-> (o_dir[gl] == DIR_0));
    end
  endgenerate

endmodule

// File: rtl/edge_grad_pipe.sv
// Four-lane smoothing plus gradient pipeline with a single stall enable.
module edge_grad_pipe
  import edge_pipe_pkg::*;
#(
  parameter int LANES = 4,
  parameter int PIX_W = 8,
  parameter int MAX_W = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [LANES*PIX_W-1:0]        in_data,
  input  logic                          in_sof,
  input  logic                          in_eol,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [LANES*(PIX_W+2)-1:0]    out_data,
  output logic                          out_sof,
  output logic                          out_eol
);

  localparam int GW = PIX_W + 3;
  localparam int RW = PIX_W + 2;

  logic en;
  logic [LANES-1:0][PIX_W-1:0] pix_in;

  logic                                   a_v, a_sof, a_eol;
  logic [LANES-1:0][2:0][2:0][PIX_W-1:0]  a_win;
  logic                                   s_v, s_sof, s_eol;
  logic [LANES-1:0][PIX_W-1:0]            s_pix;
  logic                                   b_v, b_sof, b_eol;
  logic [LANES-1:0][2:0][2:0][PIX_W-1:0]  b_win;
  logic                                   d_v, d_sof, d_eol;
  logic signed [GW-1:0]                   d_gx [LANES];
  logic signed [GW-1:0]                   d_gy [LANES];
  logic [LANES-1:0][PIX_W-1:0]            o_mag;
  dir_e                                   o_dir [LANES];

  assign en       = !out_valid || out_ready;
  assign in_ready = en;
  assign pix_in   = in_data;

  ep_window #(.LANES(LANES), .PW(PIX_W), .MAX_W(MAX_W)) u_win_a (
    .clk(clk), .rst_n(rst_n), .en(en),
    .in_v(in_valid), .in_pix(pix_in), .in_sof(in_sof), .in_eol(in_eol),
    .w_v(a_v), .w_sof(a_sof), .w_eol(a_eol), .w_win(a_win)
  );

  ep_smooth #(.LANES(LANES), .PW(PIX_W)) u_smooth (
    .clk(clk), .rst_n(rst_n), .en(en),
    .w_v(a_v), .w_sof(a_sof), .w_eol(a_eol), .w_win(a_win),
    .g_v(s_v), .g_sof(s_sof), .g_eol(s_eol), .g_pix(s_pix)
  );

  ep_window #(.LANES(LANES), .PW(PIX_W), .MAX_W(MAX_W)) u_win_b (
    .clk(clk), .rst_n(rst_n), .en(en),
    .in_v(s_v), .in_pix(s_pix), .in_sof(s_sof), .in_eol(s_eol),
    .w_v(b_v), .w_sof(b_sof), .w_eol(b_eol), .w_win(b_win)
  );

  ep_grad #(.LANES(LANES), .PW(PIX_W), .GW(GW)) u_grad (
    .clk(clk), .rst_n(rst_n), .en(en),
    .w_v(b_v), .w_sof(b_sof), .w_eol(b_eol), .w_win(b_win),
    .d_v(d_v), .d_sof(d_sof), .d_eol(d_eol), .d_gx(d_gx), .d_gy(d_gy)
  );

  ep_magdir #(.LANES(LANES), .PW(PIX_W), .GW(GW)) u_magdir (
    .clk(clk), .rst_n(rst_n), .en(en),
    .d_v(d_v), .d_sof(d_sof), .d_eol(d_eol), .d_gx(d_gx), .d_gy(d_gy),
    .o_v(out_valid), .o_sof(out_sof), .o_eol(out_eol),
    .o_mag(o_mag), .o_dir(o_dir)
  );

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      out_data[l*RW +: RW] = {o_dir[l], o_mag[l]};
    end
  end

  // Beats held inside the pipeline, for the depth check below.
  logic [3:0] inflight_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight_q <= '0;
    end else begin
      case ({in_valid && in_ready, out_valid && out_ready})
        2'b10:   inflight_q <= inflight_q + 4'd1;
        2'b01:   inflight_q <= inflight_q - 4'd1;
        default: inflight_q <= inflight_q;
      endcase
    end
  end

  // R1: beats are neither lost nor invented; no more than the register slots.
  p_depth_r1: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q <= 4'(PIPE_STAGES));

  // R9: a refused output beat is held unchanged.
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) &&
                                  $stable(out_sof) && $stable(out_eol));

endmodule

// File: tb/sim_edge_grad_pipe.sv
module sim_edge_grad_pipe;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 4;
  localparam int PW         = 8;
  localparam int RW         = PW + 2;
  localparam int OW         = LANES * RW;
  localparam int MAXR       = 16;
  localparam int MAXC       = 64;
  localparam int WD_CYCLES  = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [LANES*PW-1:0] in_data = '0;
  logic              in_sof = 1'b0;
  logic              in_eol = 1'b0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [OW-1:0]     out_data;
  logic              out_sof;
  logic              out_eol;

  int checks = 0;
  int failures = 0;
  int img [MAXR][MAXC];

  edge_grad_pipe #(.LANES(LANES), .PIX_W(PW), .MAX_W(256)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eol(out_eol)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * WD_CYCLES);
    failures++;
    $display("FAIL watchdog expired R1 act=%0d exp=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Reference model from the requirements.
  function automatic int px(int y, int x);
    return img[(y < 0) ? 0 : y][(x < 0) ? 0 : x];
  endfunction

  function automatic int smooth(int y, int x);
    int s = 0;
    if (y < 0) y = 0;
    if (x < 0) x = 0;
    for (int dy = 0; dy < 3; dy++)
      for (int dx = 0; dx < 3; dx++)
        s += ((dy == 1) ? 2 : 1) * ((dx == 1) ? 2 : 1) * px(y-2+dy, x-2+dx);
    return s >> 4;
  endfunction

  function automatic int expect_lane(int y, int x);
    int gx = 0, gy = 0, ax, ay, mag, dir;
    for (int i = 0; i < 3; i++) begin
      int w = (i == 1) ? 2 : 1;
      gx += w * (smooth(y-2+i, x) - smooth(y-2+i, x-2));
      gy += w * (smooth(y, x-2+i) - smooth(y-2, x-2+i));
    end
    ax = (gx < 0) ? -gx : gx;
    ay = (gy < 0) ? -gy : gy;
    mag = (ax + ay > 255) ? 255 : ax + ay;
    if (ay * 256 <= 106 * ax)      dir = 0;
    else if (ay * 256 >= 618 * ax) dir = 2;
    else if ((gx < 0) == (gy < 0)) dir = 1;
    else                           dir = 3;
    return dir * 256 + mag;
  endfunction

  function automatic string tag_for(int y, int x, int fidx);
    string s = "R2 R3 R4 R5";
    if (y < 2 || x < 2) s = {s, " R6"};
    if (x >= 4 && (x % 4) < 2) s = {s, " R7"};
    if (fidx > 0 && y < 2) s = {s, " R11"};
    return s;
  endfunction

  task automatic fill(int pat, int wb, int h);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < wb * 4; x++) begin
        case (pat)
          0: img[y][x] = int'($urandom % 256);
          1: img[y][x] = 77;
          2: img[y][x] = (x >= wb * 2) ? 255 : 0;
          3: img[y][x] = (y >= h / 2) ? 255 : 0;
          4: img[y][x] = ((x + y) % 2 == 1) ? 255 : 0;
          default: img[y][x] = ((x + y) * 16 > 255) ? 255 : (x + y) * 16;
        endcase
      end
  endtask

  task automatic drive_beat(int idx, int wb);
    int y = idx / wb;
    int cb = idx % wb;
    for (int l = 0; l < LANES; l++) in_data[l*PW +: PW] = PW'(img[y][cb*4+l]);
    in_sof   = (idx == 0);
    in_eol   = (cb == wb - 1);
    in_valid = 1'b1;
  endtask

  task automatic check_out(int idx, int wb, int fidx);
    int y = idx / wb;
    int cb = idx % wb;
    for (int l = 0; l < LANES; l++) begin
      int x = cb * 4 + l;
      int act = int'(out_data[l*RW +: RW]);
      int exp = expect_lane(y, x);
      check(act == exp, tag_for(y, x, fidx), act, exp);
    end
    check(out_sof == (idx == 0), "R8 sof", int'(out_sof), int'(idx == 0));
    check(out_eol == (cb == wb - 1), "R8 eol", int'(out_eol), int'(cb == wb - 1));
  endtask

  task automatic run_frame(int wb, int h, int vm, int rm, int fidx);
    int total = wb * h;
    int ni = 0, no = 0;
    bit acc_prev = 0, hold = 0;
    logic [OW-1:0] hd = '0;
    logic hs = 0, he = 0;
    while (no < total) begin
      @(negedge clk);
      if (acc_prev) begin
        in_valid = 1'b0;
        acc_prev = 0;
      end
      if (!in_valid && ni < total && (vm == 0 || ($urandom % 3) != 0))
        drive_beat(ni, wb);
      out_ready = (rm == 0) || (($urandom % 3) != 0);
      #1;
      check(in_ready == (!out_valid || out_ready), "R9 ready",
            int'(in_ready), int'(!out_valid || out_ready));
      if (hold)
        check(out_valid && out_data == hd && out_sof == hs && out_eol == he,
              "R9 hold", int'(out_valid), 1);
      hold = out_valid && !out_ready;
      hd = out_data; hs = out_sof; he = out_eol;
      if (out_valid && out_ready) begin
        check_out(no, wb, fidx);
        no++;
      end
      if (in_valid && in_ready) begin
        ni++;
        acc_prev = 1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    check(ni == total, "R1 count", ni, total);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      #1;
      check(!out_valid, "R1 no extra beat", int'(out_valid), 0);
    end
  endtask

  task automatic latency_test(int fidx);
    img[0][0] = 10; img[0][1] = 50; img[0][2] = 90; img[0][3] = 200;
    @(negedge clk);
    out_ready = 1'b1;
    drive_beat(0, 1);
    #1;
    check(in_ready, "R10 accept", int'(in_ready), 1);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      if (k < 5) check(!out_valid, "R10 early", int'(out_valid), 0);
      else begin
        check(out_valid, "R10 due", int'(out_valid), 1);
        check_out(0, 1, fidx);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R11 reset valid", int'(out_valid), 0);
    check(in_ready, "R11 reset ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    latency_test(0);
    fill(0, 8, 6);  run_frame(8, 6, 1, 1, 1);
    fill(1, 2, 3);  run_frame(2, 3, 0, 0, 2);
    fill(2, 4, 5);  run_frame(4, 5, 1, 0, 3);
    fill(3, 3, 6);  run_frame(3, 6, 0, 1, 4);
    fill(4, 4, 4);  run_frame(4, 4, 1, 1, 5);
    fill(5, 4, 6);  run_frame(4, 6, 0, 0, 6);
    fill(0, 1, 4);  run_frame(1, 4, 1, 1, 7);
    fill(0, 16, 8); run_frame(16, 8, 0, 0, 8);
    fill(0, 5, 7);  run_frame(5, 7, 1, 1, 9);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule